// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit timer/counter made of two byte halves, with a companion 16-bit capture/reload register. The timer counts either internal prescaled ticks or falling transitions of an external count pin. It has four operating states: capture, reload counting upward, reload counting up or down, and baud generation. A small byte-wide register bus configures the mode, reads and writes the counter and reload halves, and clears the two status flags.

In capture mode a falling edge on the trigger pin copies the running count into the capture/reload register. In the reload states the counter reloads when it overflows, or when it underflows while counting down. In baud mode each overflow reloads the counter and emits a one-cycle tick for a serial transmitter. An overflow flag and an external-event flag share one interrupt request line.

Top module: `cr_timer`

Operating states (register `st_q`, type `tmr_state_e`): `ST_CAPT`, `ST_RUP`, `ST_RUD`, `ST_BAUD`. The state is updated on every clock from the control bits, with these transitions:
- `to_baud`: from any state to `ST_BAUD` when the baud bit is set.
- `to_updown`: from any state to `ST_RUD` when the reload bit and the direction-enable bit are set and the baud bit is clear.
- `to_reload`: from any state to `ST_RUP` when the reload bit is set and both the baud bit and the direction-enable bit are clear.
- `to_capture`: from any state to `ST_CAPT` when the baud bit and the reload bit are both clear.

A new control value takes effect on the cycle after it is written.

Register map (3-bit address, 8-bit data):
- 0 CTRL: bit0 run, bit1 count source (1 = count pin), bit2 trigger enable, bit3 reload mode, bit4 baud mode, bit6 event flag, bit7 overflow flag.
- 1 MODEX: bit0 output enable (stored only), bit1 direction enable. Bits 7:2 read as 0.
- 2 and 3: counter low and high byte.
- 4 and 5: reload low and high byte.

## Requirements
- R1: After reset, CTRL, MODEX, both counter bytes and both reload bytes read 0x00, and `flag_ovf`, `flag_ext`, `irq` and `baud_tick` are all 0.
- R2: While CTRL bit0 (run) is 0, count events leave the counter unchanged.
- R3: In capture state each count event adds 1 to the counter. A count event at 0xFFFF gives 0x0000 and sets the overflow flag (CTRL bit7).
- R4: In capture state with CTRL bit2 set, a falling trigger edge copies the counter into the reload register and sets the event flag (CTRL bit6). With bit2 clear, the edge changes neither the reload register nor the flag.
- R5: `irq` is high when the overflow flag is set, or when the event flag is set outside the up/down state. In the up/down state the event flag alone does not raise `irq`.
- R6: In reload-up state a count event at 0xFFFF loads the reload value and sets the overflow flag. At any other value the event adds 1.
- R7: In reload-up state with CTRL bit2 set, a falling trigger edge loads the reload value into the counter and sets the event flag.
- R8: In up/down state (CTRL bit3 and MODEX bit1 set) a high trigger level counts up, as in R6, and a low level counts down. A down event at a count equal to the reload value loads 0xFFFF. Every overflow or underflow sets the overflow flag and inverts the event flag.
- R9: In baud state a count event at 0xFFFF loads the reload value and pulses `baud_tick` for one cycle, without setting the overflow flag. With the internal source the counter steps once every two `clk_en` cycles.
- R10: Writing CTRL with bit7 or bit6 at 0 clears that flag. Writing 1 leaves the flag unchanged.
- R11: Only MODEX bits 1:0 are writable, and bits 7:2 read as 0.
- R12: The count and trigger pins are sampled on successive clocks. A high sample followed by a low sample is one edge event, lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Oscillator enable feeding the prescaler |
| cnt_pin | input | 1 | External count source, counts on falling edges |
| trig_pin | input | 1 | External trigger and direction pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| flag_ovf | output | 1 | Overflow flag |
| flag_ext | output | 1 | External-event flag |
| irq | output | 1 | Shared interrupt request |
| baud_tick | output | 1 | One-cycle pulse on each baud overflow |

## Verification
The assertions assume the pins idle high at reset, so the edge detector's preset samples produce no false edge. They also assume the internal prescaler sees a steady or regularly toggling `clk_en`. The bench holds both pins high through reset. It generates each count or trigger edge by holding a pin level for two clocks. It changes the trigger level only while the trigger enable is clear, or in the up/down state, where edges are ignored. Control changes always get a few settling cycles, which covers the one-cycle delay of the state register.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

    typedef enum logic [1:0] {
        ST_CAPT = 2'd0,
        ST_RUP  = 2'd1,
        ST_RUD  = 2'd2,
        ST_BAUD = 2'd3
    } tmr_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODEX  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;

    localparam int B_RUN   = 0;
    localparam int B_SRC   = 1;
    localparam int B_TEN   = 2;
    localparam int B_RLD   = 3;
    localparam int B_BAUD  = 4;
    localparam int B_EXTF  = 6;
    localparam int B_OVFF  = 7;

    localparam int B_OEN   = 0;
    localparam int B_DIREN = 1;

endpackage

// File: rtl/cr_timer_edge.sv
module cr_timer_edge #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin,
    output logic [NPIN-1:0] fall,
    output logic [NPIN-1:0] lvl
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic s_new;
        logic s_old;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_new <= 1'b1;
                s_old <= 1'b1;
            end else begin
                s_new <= pin[i];
                s_old <= s_new;
            end
        end

        assign fall[i] = s_old & ~s_new;
        assign lvl[i]  = s_new;

        // R12
        trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end

endmodule

// File: rtl/cr_timer_prescale.sv
module cr_timer_prescale #(
    parameter int CYC_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic st_tick,
    output logic cyc_tick
);

    localparam int CYC_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_DIV - 1);

    logic             ph_q;
    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            cyc_q <= '0;
        end else if (clk_en) begin
            ph_q  <= ~ph_q;
            cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
        end
    end

    assign st_tick  = clk_en & ph_q;
    assign cyc_tick = clk_en & (cyc_q == CYC_LAST);

    // R9
    state_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_tick |=> !st_tick);

endmodule

// File: rtl/cr_timer_core.sv
module cr_timer_core
    import cr_timer_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  ext_src,
    input  logic                  ext_en,
    input  logic                  reload_mode,
    input  logic                  baud_mode,
    input  logic                  dir_en,
    input  logic                  cnt_fall,
    input  logic                  trig_fall,
    input  logic                  trig_lvl,
    input  logic                  st_tick,
    input  logic                  cyc_tick,
    input  logic [3:0]            wr_byte,
    input  logic [HALF_W-1:0]     wdata,
    input  logic                  clr_ovf,
    input  logic                  clr_ext,
    output logic [2*HALF_W-1:0]   cnt,
    output logic [2*HALF_W-1:0]   rld,
    output logic                  flag_ovf,
    output logic                  flag_ext,
    output logic                  baud_tick,
    output logic                  updown
);

    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_state_e st_q, st_d;

    logic [CNT_W-1:0] cnt_q, cnt_n, rld_q, rld_n;
    logic ovf_q, ext_q, btick_q;
    logic evt, ovf_set, ext_set, ext_tog, btick, wrap_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CAPT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CAPT, ST_RUP, ST_RUD, ST_BAUD: begin
                if (baud_mode)                st_d = ST_BAUD;
                else if (reload_mode && dir_en) st_d = ST_RUD;
                else if (reload_mode)         st_d = ST_RUP;
                else                          st_d = ST_CAPT;
            end
            default: st_d = ST_CAPT;
        endcase
    end

    assign evt = run & (ext_src ? cnt_fall : ((st_q == ST_BAUD) ? st_tick : cyc_tick));

    // datapath by state
    always_comb begin
        cnt_n   = cnt_q;
        rld_n   = rld_q;
        ovf_set = 1'b0;
        ext_set = 1'b0;
        ext_tog = 1'b0;
        btick   = 1'b0;
        unique case (st_q)
            ST_CAPT: begin
                if (evt) begin
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == CNT_MAX) ovf_set = 1'b1;
                end
                if (ext_en && trig_fall) begin
                    rld_n   = cnt_q;
                    ext_set = 1'b1;
                end
            end
            ST_RUP: begin
                if (ext_en && trig_fall) begin
                    cnt_n   = rld_q;
                    ext_set = 1'b1;
                end else if (evt) begin
                    if (cnt_q == CNT_MAX) begin
                        cnt_n   = rld_q;
                        ovf_set = 1'b1;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_RUD: begin
                if (evt) begin
                    if (trig_lvl) begin
                        if (cnt_q == CNT_MAX) begin
                            cnt_n   = rld_q;
                            ovf_set = 1'b1;
                            ext_tog = 1'b1;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end else begin
                        if (cnt_q == rld_q) begin
                            cnt_n   = CNT_MAX;
                            ovf_set = 1'b1;
                            ext_tog = 1'b1;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
            end
            ST_BAUD: begin
                if (evt) begin
                    if (cnt_q == CNT_MAX) begin
                        cnt_n = rld_q;
                        btick = 1'b1;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                if (ext_en && trig_fall) ext_set = 1'b1;
            end
            default: ;
        endcase
        for (int h = 0; h < 2; h++) begin
            if (wr_byte[h])     cnt_n[h*HALF_W +: HALF_W] = wdata;
            if (wr_byte[h + 2]) rld_n[h*HALF_W +: HALF_W] = wdata;
        end
    end

    assign wrap_evt = ovf_set | btick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rld_q   <= '0;
            ovf_q   <= 1'b0;
            ext_q   <= 1'b0;
            btick_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            rld_q   <= rld_n;
            btick_q <= btick;
            if (ovf_set)      ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;
            if (ext_set)      ext_q <= 1'b1;
            else if (ext_tog) ext_q <= ~ext_q;
            else if (clr_ext) ext_q <= 1'b0;
        end
    end

    assign cnt       = cnt_q;
    assign rld       = rld_q;
    assign flag_ovf  = ovf_q;
    assign flag_ext  = ext_q;
    assign baud_tick = btick_q;
    assign updown    = (st_q == ST_RUD);

    // R3
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> $past(wrap_evt) && ($past(st_q) != ST_BAUD));

    // R4
    ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ext) |-> $past(trig_fall) || $past(wrap_evt));

    // R2
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && (wr_byte[1:0] == 2'b00) && !(ext_en && trig_fall)) |=> $stable(cnt_q));

    // R9
    baud_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(st_q) == ST_BAUD);

endmodule

// File: rtl/cr_timer.sv
module cr_timer
    import cr_timer_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int CYC_DIV = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              flag_ovf,
    output logic              flag_ext,
    output logic              irq,
    output logic              baud_tick
);

    localparam int CNT_W = 2 * HALF_W;

    logic run_q, src_q, ten_q, rldm_q, baudm_q, oen_q, diren_q;
    logic [1:0] fall, lvl;
    logic st_tick, cyc_tick, updown;
    logic [3:0] wr_byte;
    logic [CNT_W-1:0] cnt, rld;
    logic wr_ctrl, wr_modex;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_modex = bus_wr && (bus_addr == A_MODEX);
    assign wr_byte  = {bus_wr && (bus_addr == A_RLD_HI), bus_wr && (bus_addr == A_RLD_LO),
                       bus_wr && (bus_addr == A_CNT_HI), bus_wr && (bus_addr == A_CNT_LO)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            src_q   <= 1'b0;
            ten_q   <= 1'b0;
            rldm_q  <= 1'b0;
            baudm_q <= 1'b0;
            oen_q   <= 1'b0;
            diren_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run_q   <= bus_wdata[B_RUN];
                src_q   <= bus_wdata[B_SRC];
                ten_q   <= bus_wdata[B_TEN];
                rldm_q  <= bus_wdata[B_RLD];
                baudm_q <= bus_wdata[B_BAUD];
            end
            if (wr_modex) begin
                oen_q   <= bus_wdata[B_OEN];
                diren_q <= bus_wdata[B_DIREN];
            end
        end
    end

    cr_timer_edge #(.NPIN(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({trig_pin, cnt_pin}),
        .fall (fall),
        .lvl  (lvl)
    );

    cr_timer_prescale #(.CYC_DIV(CYC_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .st_tick (st_tick),
        .cyc_tick(cyc_tick)
    );

    cr_timer_core #(.HALF_W(HALF_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .ext_src    (src_q),
        .ext_en     (ten_q),
        .reload_mode(rldm_q),
        .baud_mode  (baudm_q),
        .dir_en     (diren_q),
        .cnt_fall   (fall[0]),
        .trig_fall  (fall[1]),
        .trig_lvl   (lvl[1]),
        .st_tick    (st_tick),
        .cyc_tick   (cyc_tick),
        .wr_byte    (wr_byte),
        .wdata      (bus_wdata),
        .clr_ovf    (wr_ctrl && !bus_wdata[B_OVFF]),
        .clr_ext    (wr_ctrl && !bus_wdata[B_EXTF]),
        .cnt        (cnt),
        .rld        (rld),
        .flag_ovf   (flag_ovf),
        .flag_ext   (flag_ext),
        .baud_tick  (baud_tick),
        .updown     (updown)
    );

    assign irq = flag_ovf | (flag_ext & ~updown);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_RUN]  = run_q;
                bus_rdata[B_SRC]  = src_q;
                bus_rdata[B_TEN]  = ten_q;
                bus_rdata[B_RLD]  = rldm_q;
                bus_rdata[B_BAUD] = baudm_q;
                bus_rdata[B_EXTF] = flag_ext;
                bus_rdata[B_OVFF] = flag_ovf;
            end
            A_MODEX: begin
                bus_rdata[B_OEN]   = oen_q;
                bus_rdata[B_DIREN] = diren_q;
            end
            A_CNT_LO: bus_rdata = cnt[HALF_W-1:0];
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF_W];
            A_RLD_LO: bus_rdata = rld[HALF_W-1:0];
            A_RLD_HI: bus_rdata = rld[CNT_W-1:HALF_W];
            default:  bus_rdata = '0;
        endcase
    end

    // R5
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_ovf || flag_ext);

endmodule

// File: tb/test_cr_timer.sv
module test_cr_timer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1;
    logic cnt_pin = 1'b1;
    logic trig_pin = 1'b1;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic flag_ovf, flag_ext, irq, baud_tick;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit half_en = 1'b0;
    int cyc = 0;
    int bcnt = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (baud_tick) bcnt <= bcnt + 1;
    end

    always @(negedge clk) if (half_en) clk_en <= ~clk_en;

    cr_timer i_cr_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_ovf(flag_ovf), .flag_ext(flag_ext), .irq(irq), .baud_tick(baud_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] r);
        wr(3'd0, 8'h00);
        wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
        wr(3'd4, r[7:0]); wr(3'd5, r[15:8]);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_pin = 1'b0;
            idle(2);
            cnt_pin = 1'b1;
            idle(2);
        end
        idle(3);
    endtask

    task automatic trig_fall_pulse();
        @(negedge clk); trig_pin = 1'b0;
        idle(2);
        trig_pin = 1'b1;
        idle(4);
    endtask

    // md: 0 capture, 1 reload up, 2 up/down, 3 baud; nev counts wraps
    function automatic void model(input int md, input logic [15:0] st, input logic [15:0] rl,
                                  input bit up, input int n, output logic [15:0] fin,
                                  output int nev);
        logic [15:0] c = st;
        nev = 0;
        for (int i = 0; i < n; i++) begin
            if (md == 2 && !up) begin
                if (c == rl) begin c = 16'hFFFF; nev++; end
                else c = c - 16'd1;
            end else if (c == 16'hFFFF) begin
                c = (md == 0) ? 16'h0000 : rl;
                nev++;
            end else c = c + 16'd1;
        end
        fin = c;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [15:0] w, fin;
        logic [15:0] starts [4];
        int nev, t0, t1, b0;
        starts = '{16'h0000, 16'h00FE, 16'hFFFA, 16'h7FFF};

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            chk("R1 reg", b, 0);
        end
        chk("R1 outputs", {flag_ovf, flag_ext, irq, baud_tick}, 0);

        // R11 mode register writable bits
        wr(3'd1, 8'hFF); rd(3'd1, b); chk("R11 modex", b, 8'h03);
        wr(3'd1, 8'h00); rd(3'd1, b); chk("R11 modex clear", b, 8'h00);

        // R3 capture-state counting sweep
        foreach (starts[s]) begin
            for (int n = 1; n <= 7; n += 3) begin
                setup(starts[s], 16'h0000);
                wr(3'd0, 8'h03);
                idle(3);
                pulses(n);
                model(0, starts[s], 16'h0000, 1'b1, n, fin, nev);
                rd16(3'd2, w); chk("R3 count", w, fin);
                rd(3'd0, b); chk("R3 ovf flag", b[7], nev > 0);
                chk("R5 irq", irq, nev > 0);
            end
        end

        // R2 halted
        setup(16'h0042, 16'h0000);
        wr(3'd0, 8'h02);
        idle(3);
        pulses(5);
        rd16(3'd2, w); chk("R2 halted count", w, 16'h0042);

        // R4 capture trigger, enabled then disabled
        setup(16'h1234, 16'h0000);
        wr(3'd0, 8'h04); idle(3);
        trig_fall_pulse();
        rd16(3'd4, w); chk("R4 captured", w, 16'h1234);
        rd(3'd0, b); chk("R4 event flag", b[6], 1);
        chk("R5 irq from event", irq, 1);
        setup(16'h5678, 16'h0000);
        idle(3);
        trig_fall_pulse();
        rd16(3'd4, w); chk("R4 disabled capture", w, 16'h0000);
        rd(3'd0, b); chk("R4 disabled flag", b[6], 0);

        // R10 flag write semantics
        wr(3'd0, 8'hC4); rd(3'd0, b); chk("R10 write one no set", b[7:6], 0);
        trig_fall_pulse();
        wr(3'd0, 8'hC4); rd(3'd0, b); chk("R10 write one keeps", b[6], 1);
        wr(3'd0, 8'h84); rd(3'd0, b); chk("R10 write zero clears", b[6], 0);

        // R6 reload-up sweep
        for (int r = 0; r < 2; r++) begin
            for (int s = 0; s < 2; s++) begin
                for (int n = 2; n <= 20; n += 9) begin
                    logic [15:0] rv, sv;
                    rv = r ? 16'h8000 : 16'hFFF0;
                    sv = s ? 16'hFFFF : 16'hFFFC;
                    setup(sv, rv);
                    wr(3'd0, 8'h0B);
                    idle(3);
                    pulses(n);
                    model(1, sv, rv, 1'b1, n, fin, nev);
                    rd16(3'd2, w); chk("R6 count", w, fin);
                    rd(3'd0, b); chk("R6 ovf flag", b[7], nev > 0);
                end
            end
        end

        // R7 trigger-forced reload
        setup(16'h0011, 16'hABCD);
        wr(3'd0, 8'h0C); idle(3);
        trig_fall_pulse();
        rd16(3'd2, w); chk("R7 forced reload", w, 16'hABCD);
        rd(3'd0, b); chk("R7 event flag", b[6], 1);

        // R8 up/down: up sweep then down sweep
        for (int n = 1; n <= 5; n += 2) begin
            setup(16'hFFFE, 16'h1000);
            trig_pin = 1'b1;
            wr(3'd1, 8'h02);
            wr(3'd0, 8'h0B); idle(3);
            pulses(n);
            model(2, 16'hFFFE, 16'h1000, 1'b1, n, fin, nev);
            rd16(3'd2, w); chk("R8 up count", w, fin);
            rd(3'd0, b); chk("R8 up flags", b[7:6], {nev > 0, nev[0]});
        end
        for (int n = 1; n <= 6; n++) begin
            setup(16'h1003, 16'h1000);
            @(negedge clk); trig_pin = 1'b0;
            wr(3'd1, 8'h02);
            wr(3'd0, 8'h0B); idle(3);
            pulses(n);
            model(2, 16'h1003, 16'h1000, 1'b0, n, fin, nev);
            rd16(3'd2, w); chk("R8 down count", w, fin);
            rd(3'd0, b); chk("R8 down flags", b[7:6], {nev > 0, nev[0]});
            trig_pin = 1'b1;
        end
        // R5: event flag alone raises no irq in up/down state
        setup(16'h1002, 16'h1000);
        @(negedge clk); trig_pin = 1'b0;
        wr(3'd0, 8'h0B); idle(3);
        pulses(3);
        wr(3'd0, 8'h4B); idle(1);
        chk("R5 no irq from toggled flag", {flag_ext, irq}, 2'b10);
        wr(3'd0, 8'h00);
        @(negedge clk); trig_pin = 1'b1;
        wr(3'd1, 8'h00);
        idle(3);

        // R9 baud with count pin
        for (int n = 3; n <= 9; n += 3) begin
            setup(16'hFFFD, 16'hFFFD);
            wr(3'd0, 8'h13); idle(3);
            b0 = bcnt;
            pulses(n);
            model(3, 16'hFFFD, 16'hFFFD, 1'b1, n, fin, nev);
            rd16(3'd2, w); chk("R9 baud count", w, fin);
            chk("R9 baud ticks", bcnt - b0, nev);
            rd(3'd0, b); chk("R9 no ovf flag", b[7], 0);
        end

        // R9 internal source tick interval, full then half clock enable
        for (int h = 0; h < 2; h++) begin
            setup(16'hFFF0, 16'hFFF0);
            @(negedge clk); half_en = h[0];
            wr(3'd0, 8'h11);
            do @(negedge clk); while (!baud_tick);
            t0 = cyc;
            do @(negedge clk); while (!baud_tick);
            t1 = cyc;
            chk("R9 tick period", t1 - t0, 32 * (h + 1));
            half_en = 1'b0;
            @(negedge clk); clk_en = 1'b1;
        end

        // R12 single edge event: one long low pulse counts once
        setup(16'h0000, 16'h0000);
        wr(3'd0, 8'h03); idle(3);
        @(negedge clk); cnt_pin = 1'b0;
        idle(10);
        cnt_pin = 1'b1;
        idle(4);
        rd16(3'd2, w); chk("R12 one event per edge", w, 16'h0001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule